// File: doc/BRIEF.md
# GPIO Bank Controller with Per-Pin Masked Writes

This block controls a set of general-purpose pins through a 32-bit register interface. Pins are grouped in ports of eight. Four ports make a bank, and the number of banks is a parameter. Each pin has six stored bits: GPIO-mode select, output enable, output value, interrupt enable, edge select and interrupt status. The sampled pad level can also be read. Each pad gets an output value and an output enable from the block, and the block returns the pad's input level.

Every writable register also has an alias at +0x80 for masked writes. In the alias, the upper byte of the write data picks which pins change, and the lower byte gives their new values. Software can therefore change one pin without a read-modify-write. Pad inputs pass through a two-flop synchronizer. Edges on pins in GPIO mode set status bits, and status bits are cleared through a separate write-one-to-clear register. A single interrupt output combines all enabled pending bits. With the default parameters, the last port of the last bank is left out.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After synchronous reset, every stored bit is 0, so `pad_oe` is all zeros and `irq` is low.
- R2: The address is decoded as follows:
  - Bits [ADDR_W-1:8] select the bank, and address bits [3:2] select the port within the bank.
  - Bits [6:4] select the register group: 0 mode, 1 output enable, 2 output value, 3 input, 4 status, 5 interrupt enable, 6 edge select, 7 clear.
  - A plain write (address bit 7 = 0) loads `wdata[7:0]` into the addressed port and ignores `wdata[31:8]`.
  - A read returns the port's byte in `rdata[7:0]`, with bits 31:8 at zero.
- R3: A write with address bit 7 = 1 is masked. Pin n takes `wdata[n]` only when `wdata[8+n]` is 1; every other pin keeps its value. A read of such an alias returns the underlying register.
- R4: `pad_oe` of a pin is 1 only when both its mode bit and its output-enable bit are 1. `pad_out` always presents the output-value bit.
- R5: The input group returns the pad level two clock edges after it changes, whatever the pin's direction. Writes to this group have no effect.
- R6: Edge detection applies only to a pin whose mode bit is 1:
  - If its edge-select bit is 1, a rising edge on the synchronized input sets its status bit; if the bit is 0, a falling edge does.
  - The status bit is set whether or not the pin's interrupt is enabled.
- R7: A plain write to the clear group clears each status bit whose data bit is 1. Data bits at 0 have no effect, and the clear group reads as 0.
- R8: If an edge and a clear hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq` is the OR, over all pins, of status AND interrupt enable.
- R10: The following read as 0 and ignore writes: a nonexistent port, the masked input alias (0xB0) and the masked clear alias (0xF0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_out | output | NUM_PINS | Output value per pin |
| pad_oe | output | NUM_PINS | Output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a clear write and a newly detected edge landing on the same status bit in the same cycle. The edge becomes visible only after two synchronizer stages and the edge-history flop, so it appears three clock edges after the pad moves. The stimulus therefore changes the pad on a falling clock edge, waits exactly two rising edges, and then presents the clear write so that it is captured together with the edge. Masked writes are checked with mixed mask patterns against a behavioural model that is compared on every clock.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PINS_PER_PORT  = 8;
    localparam int PORTS_PER_BANK = 4;
    localparam int BANK_STRIDE_LG = 8;

    typedef enum logic [2:0] {
        GRP_MODE = 3'd0,
        GRP_OE   = 3'd1,
        GRP_OUT  = 3'd2,
        GRP_IN   = 3'd3,
        GRP_STS  = 3'd4,
        GRP_IEN  = 3'd5,
        GRP_EDGE = 3'd6,
        GRP_CLR  = 3'd7
    } reg_grp_e;

    typedef struct packed {
        logic [PINS_PER_PORT-1:0] mode;
        logic [PINS_PER_PORT-1:0] oe;
        logic [PINS_PER_PORT-1:0] out;
        logic [PINS_PER_PORT-1:0] sts;
        logic [PINS_PER_PORT-1:0] ien;
        logic [PINS_PER_PORT-1:0] edge_sel;
    } port_regs_t;

    // Plain write replaces the byte; masked write updates only enabled pins.
    function automatic logic [PINS_PER_PORT-1:0] merge_write(
        input logic [PINS_PER_PORT-1:0]   cur,
        input logic [2*PINS_PER_PORT-1:0] data,
        input logic                       masked
    );
        logic [PINS_PER_PORT-1:0] sel;
        sel = masked ? data[2*PINS_PER_PORT-1:PINS_PER_PORT] : '1;
        return (cur & ~sel) | (data[PINS_PER_PORT-1:0] & sel);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    // Cycles since reset, saturating, used to gate the latency check.
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (q == $past(d, 2))); // R5

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic                       masked,
    input  reg_grp_e                   grp,
    input  logic [2*PINS_PER_PORT-1:0] wdata,
    input  logic [PINS_PER_PORT-1:0]   pin_in,
    output port_regs_t                 regs,
    output logic [PINS_PER_PORT-1:0]   rd_byte,
    output logic                       irq
);
    port_regs_t               nxt;
    logic [PINS_PER_PORT-1:0] prev_in;
    logic [PINS_PER_PORT-1:0] rise, fall, edge_hit;

    assign rise     = pin_in & ~prev_in;
    assign fall     = ~pin_in & prev_in;
    assign edge_hit = regs.mode & ((regs.edge_sel & rise) | (~regs.edge_sel & fall));

    always_comb begin
        nxt = regs;
        if (wr_en) begin
            unique case (grp)
                GRP_MODE: nxt.mode     = merge_write(regs.mode, wdata, masked);
                GRP_OE:   nxt.oe       = merge_write(regs.oe, wdata, masked);
                GRP_OUT:  nxt.out      = merge_write(regs.out, wdata, masked);
                GRP_STS:  nxt.sts      = merge_write(regs.sts, wdata, masked);
                GRP_IEN:  nxt.ien      = merge_write(regs.ien, wdata, masked);
                GRP_EDGE: nxt.edge_sel = merge_write(regs.edge_sel, wdata, masked);
                GRP_CLR:  if (!masked) nxt.sts = regs.sts & ~wdata[PINS_PER_PORT-1:0];
                default:  ;
            endcase
        end
        // A fresh edge overrides a clear in the same cycle.
        nxt.sts = nxt.sts | edge_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs    <= '0;
            prev_in <= '0;
        end else begin
            regs    <= nxt;
            prev_in <= pin_in;
        end
    end

    always_comb begin
        unique case (grp)
            GRP_MODE: rd_byte = regs.mode;
            GRP_OE:   rd_byte = regs.oe;
            GRP_OUT:  rd_byte = regs.out;
            GRP_IN:   rd_byte = masked ? '0 : pin_in;
            GRP_STS:  rd_byte = regs.sts;
            GRP_IEN:  rd_byte = regs.ien;
            GRP_EDGE: rd_byte = regs.edge_sel;
            default:  rd_byte = '0;
        endcase
    end

    assign irq = |(regs.sts & regs.ien);

    AST_MASK_KEEPS_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && masked && grp == GRP_MODE) |=>
        ((regs.mode & ~$past(wdata[15:8])) == ($past(regs.mode) & ~$past(wdata[15:8])))); // R3

    AST_EDGE_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
        (|edge_hit) |=> ((regs.sts & $past(edge_hit)) == $past(edge_hit))); // R6

    AST_STATUS_DROP_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (|($past(regs.sts) & ~regs.sts)) |->
        $past(wr_en && (grp == GRP_STS || grp == GRP_CLR))); // R7

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !masked && grp == GRP_CLR && (|(edge_hit & wdata[7:0]))) |=>
        ((regs.sts & $past(edge_hit & wdata[7:0])) == $past(edge_hit & wdata[7:0]))); // R8

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS      = 2,
    parameter bit DROP_LAST_PORT = 1'b1,
    localparam int TOTAL_PORTS   = NUM_BANKS * PORTS_PER_BANK - (DROP_LAST_PORT ? 1 : 0),
    localparam int NUM_PINS      = TOTAL_PORTS * PINS_PER_PORT,
    localparam int ADDR_W        = $clog2(NUM_BANKS) + BANK_STRIDE_LG
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);
    int       sel_idx;
    reg_grp_e grp;
    logic     masked;

    assign grp     = reg_grp_e'(addr[6:4]);
    assign masked  = addr[7];
    assign sel_idx = int'(addr >> BANK_STRIDE_LG) * PORTS_PER_BANK + int'(addr[3:2]);

    logic [PINS_PER_PORT-1:0] rd_byte [TOTAL_PORTS];
    logic [TOTAL_PORTS-1:0]   port_irq;

    for (genvar p = 0; p < TOTAL_PORTS; p++) begin : g_port
        localparam int LO = p * PINS_PER_PORT;
        logic [PINS_PER_PORT-1:0] synced;
        port_regs_t               regs;

        gpio_sync #(.WIDTH(PINS_PER_PORT)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (pad_in[LO +: PINS_PER_PORT]),
            .q   (synced)
        );

        gpio_port u_port (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en && (sel_idx == p)),
            .masked  (masked),
            .grp     (grp),
            .wdata   (wdata[2*PINS_PER_PORT-1:0]),
            .pin_in  (synced),
            .regs    (regs),
            .rd_byte (rd_byte[p]),
            .irq     (port_irq[p])
        );

        assign pad_out[LO +: PINS_PER_PORT] = regs.out;
        assign pad_oe[LO +: PINS_PER_PORT]  = regs.mode & regs.oe;
    end

    always_comb begin
        rdata = '0;
        for (int p = 0; p < TOTAL_PORTS; p++) begin
            if (sel_idx == p) rdata[PINS_PER_PORT-1:0] = rd_byte[p];
        end
    end

    assign irq = |port_irq;

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && pad_oe == '0)); // R1

    AST_UPPER_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel_idx >= TOTAL_PORTS) |-> (rdata == '0)); // R10

endmodule

// File: tb/sim_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_bank_ctrl;
    localparam int TP = 7;
    localparam int NP = TP * 8;
    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic          irq;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2 clk = ~clk;

    gpio_bank_ctrl u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // Behavioural reference state, one bit per pin.
    logic [NP-1:0] m_mode, m_oe, m_out, m_sts, m_ien, m_edge, m_s1, m_s2, m_prev;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [AW-1:0] a, input logic [31:0] d);
        int idx = int'(a >> 8) * 4 + int'(a[3:2]);
        int g   = int'(a[6:4]);
        bit msk = a[7];
        if (idx >= TP) return;
        for (int b = 0; b < 8; b++) begin
            int pin = idx * 8 + b;
            bit en  = msk ? d[8+b] : 1'b1;
            bit v   = d[b];
            if (en) begin
                case (g)
                    0: m_mode[pin] = v;
                    1: m_oe[pin]   = v;
                    2: m_out[pin]  = v;
                    4: m_sts[pin]  = v;
                    5: m_ien[pin]  = v;
                    6: m_edge[pin] = v;
                    7: if (!msk && v) m_sts[pin] = 1'b0;
                    default: ;
                endcase
            end
        end
    endtask

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        int idx = int'(a >> 8) * 4 + int'(a[3:2]);
        logic [31:0] r = '0;
        if (idx >= TP) return '0;
        case (int'(a[6:4]))
            0: r[7:0] = m_mode[idx*8 +: 8];
            1: r[7:0] = m_oe[idx*8 +: 8];
            2: r[7:0] = m_out[idx*8 +: 8];
            3: r[7:0] = a[7] ? 8'h00 : m_s2[idx*8 +: 8];
            4: r[7:0] = m_sts[idx*8 +: 8];
            5: r[7:0] = m_ien[idx*8 +: 8];
            6: r[7:0] = m_edge[idx*8 +: 8];
            default: r = '0;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        logic [NP-1:0] hit;
        if (rst) begin
            m_mode = '0; m_oe = '0; m_out = '0; m_sts = '0; m_ien = '0; m_edge = '0;
            m_s1 = '0; m_s2 = '0; m_prev = '0;
        end else begin
            hit = '0;
            for (int i = 0; i < NP; i++)
                if (m_mode[i] && (m_edge[i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i])))
                    hit[i] = 1'b1;
            if (wr_en) model_write(addr, wdata);
            m_sts  = m_sts | hit;      // edge wins over clear (R8)
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pad_in;
        end
        #1;
        if (!rst) begin
            check(pad_out === m_out, "R4 pad_out", 64'(pad_out), 64'(m_out));
            check(pad_oe === (m_mode & m_oe), "R4 pad_oe", 64'(pad_oe), 64'(m_mode & m_oe));
            check(irq === (|(m_sts & m_ien)), "R9 irq", 64'(irq), 64'(|(m_sts & m_ien)));
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        addr = a;
        #1;
        check(rdata === model_read(a), {req, " model"}, 64'(rdata), 64'(model_read(a)));
        check(rdata === exp, req, 64'(rdata), 64'(exp));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(9'h000, 32'h0, "R1 mode");
        rd(9'h010, 32'h0, "R1 oe");
        rd(9'h040, 32'h0, "R1 sts");
        rd(9'h164, 32'h0, "R1 edge");
        check(pad_oe === '0 && irq === 1'b0, "R1 pads", 64'({pad_oe, irq}), 64'(0));

        // R2 plain write ignores upper data; bank and port stride
        wr(9'h000, 32'hFFFF_FFA5);
        rd(9'h000, 32'h0000_00A5, "R2 plain write");
        wr(9'h114, 32'h0000_005A);
        rd(9'h114, 32'h0000_005A, "R2 bank1 port1");
        rd(9'h014, 32'h0, "R2 other bank untouched");

        // R3 masked alias
        rd(9'h080, 32'h0000_00A5, "R3 alias read");
        wr(9'h080, 32'h0000_0F0A);
        rd(9'h000, 32'h0000_00AA, "R3 masked low nibble");

        // R4 pad drive
        wr(9'h010, 32'h0000_00FF);
        wr(9'h020, 32'h0000_003C);
        wr(9'h090, 32'h0000_0200);
        rd(9'h010, 32'h0000_00FD, "R3 masked clear one pin");
        @(negedge clk);
        check(pad_oe[7:0] === 8'hA8, "R4 oe needs mode", 64'(pad_oe[7:0]), 64'h A8);
        check(pad_out[7:0] === 8'h3C, "R4 out value", 64'(pad_out[7:0]), 64'h3C);

        // R5 synchronizer latency and direction independence
        @(negedge clk);
        pad_in[23:16] = 8'h96;
        pad_in[7:0]   = 8'h11;
        rd(9'h038, 32'h0, "R5 one edge later");
        rd(9'h038, 32'h0000_0096, "R5 two edges later");
        rd(9'h030, 32'h0000_0011, "R5 output pins read too");
        wr(9'h030, 32'h0000_00FF);
        rd(9'h030, 32'h0000_0011, "R5 write ignored");
        rd(9'h048, 32'h0, "R6 no status outside GPIO mode");
        rd(9'h040, 32'h0, "R6 rising ignored when falling selected");

        // R6 edge detection
        wr(9'h004, 32'h0000_00FF);
        wr(9'h064, 32'h0000_000F);
        @(negedge clk); pad_in[15:8] = 8'hFF;
        idle(4);
        rd(9'h044, 32'h0000_000F, "R6 rising edges");
        @(negedge clk); pad_in[15:8] = 8'h00;
        idle(4);
        rd(9'h044, 32'h0000_00FF, "R6 falling edges");
        check(irq === 1'b0, "R9 disabled no irq", 64'(irq), 64'(0));

        // R9 and R7
        wr(9'h054, 32'h0000_0001);
        check(irq === 1'b1, "R9 irq raised", 64'(irq), 64'(1));
        wr(9'h074, 32'h0000_0000);
        rd(9'h044, 32'h0000_00FF, "R7 zeros no effect");
        wr(9'h074, 32'h0000_0081);
        rd(9'h044, 32'h0000_007E, "R7 clear ones");
        rd(9'h074, 32'h0, "R7 clear reads zero");
        check(irq === 1'b0, "R9 irq dropped", 64'(irq), 64'(0));
        wr(9'h0C4, 32'h0000_0101);
        rd(9'h044, 32'h0000_007F, "R3 masked status set");
        wr(9'h0C4, 32'h0000_0100);
        rd(9'h044, 32'h0000_007E, "R3 masked status clear");

        // R8 edge and clear captured on the same edge
        @(negedge clk); pad_in[8] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        addr = 9'h074; wdata = 32'h0000_0001; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd(9'h044, 32'h0000_007F, "R8 edge wins");
        check(irq === 1'b1, "R8 irq after race", 64'(irq), 64'(1));

        // R10 nonexistent port and undefined aliases
        wr(9'h10C, 32'h0000_00FF);
        rd(9'h10C, 32'h0, "R10 missing port");
        rd(9'h13C, 32'h0, "R10 missing port input");
        rd(9'h0B0, 32'h0, "R10 masked input alias");
        wr(9'h0F4, 32'h0000_FFFF);
        rd(9'h0F4, 32'h0, "R10 masked clear alias read");
        rd(9'h044, 32'h0000_007F, "R10 masked clear ignored");

        idle(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule